// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a virtual address into a physical address through a small table of per-segment descriptors held in flops. The upper bits of the virtual address pick one descriptor and the lower bits form an offset within that segment. Each descriptor has a base, a limit, read, write and execute permission bits, a valid bit, and reference and dirty status. The offset is compared against the limit while, in parallel, it is added to the base. The requested access type is checked against the permission bits. The registered result is either a physical address or exactly one fault flag.

Descriptors are loaded through a write port that acts only when a privileged qualifier is high. When translation is disabled, for example while the supervisor runs after a trap, the virtual address passes straight through. A small status port reads back the reference and dirty bits of any descriptor, so that replacement software can see which segments were touched.

Top module: `segxl_unit`

## Requirements
- R1: With translation on and no fault, the top SEG_W bits of `req_vaddr` select the descriptor and `rsp_paddr` equals that descriptor's base plus the low OFF_W bits, taken modulo 2^PA_W. The result appears with `rsp_valid` high on the clock edge after the request.
- R2: An offset strictly greater than the descriptor limit raises `rsp_lim_fault`. An offset equal to the limit is legal. The compare uses the raw offset, so a base-plus-offset sum that wraps past 2^PA_W raises no fault.
- R3: `req_kind` encodes 0 = read, 1 = write, 2 = execute and 3 = reserved. Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute, and the reserved kind is never allowed. An access whose kind is not allowed raises `rsp_perm_fault`.
- R4: Any translated access to a descriptor whose valid bit is clear raises `rsp_seg_fault`.
- R5: At most one fault flag is high per response, with priority segment, then limit, then permission. While a fault flag is high, `rsp_paddr` is 0.
- R6: With `xlate_en` low, a request returns `rsp_paddr` equal to `req_vaddr` zero-extended, raises no fault and leaves all reference and dirty bits unchanged.
- R7: A descriptor write (`cfg_we`) takes effect only when `cfg_priv` is high in the same cycle. Without `cfg_priv` the write is ignored.
- R8: A translated access without a fault sets the reference bit of its descriptor, and a write without a fault also sets the dirty bit. A faulting access changes neither. A privileged descriptor write clears both bits.
- R9: After reset, `rsp_valid` and all fault flags are low, every descriptor is invalid, and every reference and dirty bit is clear.
- R10: A cycle with `req_valid` low gives `rsp_valid` low and all fault flags low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Translation enable; low means pass-through |
| req_valid | input | 1 | Access request present |
| req_vaddr | input | VA_W | Virtual address |
| req_kind | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_priv | input | 1 | Privilege qualifier for descriptor writes |
| cfg_idx | input | SEG_W | Descriptor to write |
| cfg_base | input | PA_W | New segment base |
| cfg_limit | input | VA_W-SEG_W | New segment limit (last legal offset) |
| cfg_perm | input | 3 | New permissions: bit0 read, bit1 write, bit2 execute |
| cfg_valid | input | 1 | New valid bit |
| st_idx | input | SEG_W | Descriptor whose status is read |
| st_ref | output | 1 | Reference bit of descriptor `st_idx` |
| st_dirty | output | 1 | Dirty bit of descriptor `st_idx` |
| rsp_valid | output | 1 | Registered response present |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| rsp_seg_fault | output | 1 | Descriptor not valid |
| rsp_lim_fault | output | 1 | Offset beyond limit |
| rsp_perm_fault | output | 1 | Access type not permitted |

## Verification
Each response is due one clock edge after its request, through a single output register. Descriptor writes and reference and dirty updates land on that same edge. The status port reads the table combinationally, so it reflects an access as soon as that access's response is visible. The bench drives every request on a falling edge and samples the response and the status bits on the next falling edge, exactly one register stage later. It checks every request before issuing the next one, so no two expected values overlap.

// File: rtl/segxl_pkg.sv
package segxl_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_SEG  = 2'd1,
        FLT_LIM  = 2'd2,
        FLT_PERM = 2'd3
    } fault_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;
    localparam int PERM_N = 3;

endpackage

// File: rtl/segxl_table.sv
module segxl_table
    import segxl_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int SEG_W = 2,
    parameter int PA_W  = 18,
    parameter int OFF_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_priv,
    input  logic [SEG_W-1:0]  cfg_idx,
    input  logic [PA_W-1:0]   cfg_base,
    input  logic [OFF_W-1:0]  cfg_limit,
    input  logic [PERM_N-1:0] cfg_perm,
    input  logic              cfg_valid,
    input  logic [SEG_W-1:0]  lk_idx,
    output logic [PA_W-1:0]   lk_base,
    output logic [OFF_W-1:0]  lk_limit,
    output logic [PERM_N-1:0] lk_perm,
    output logic              lk_valid,
    input  logic              upd_en,
    input  logic              upd_dirty,
    input  logic [SEG_W-1:0]  upd_idx,
    input  logic [SEG_W-1:0]  st_idx,
    output logic              st_ref,
    output logic              st_dirty
);

    typedef struct packed {
        logic [NSEG-1:0][PA_W-1:0]   base;
        logic [NSEG-1:0][OFF_W-1:0]  limit;
        logic [NSEG-1:0][PERM_N-1:0] perm;
        logic [NSEG-1:0]             valid;
        logic [NSEG-1:0]             refd;
        logic [NSEG-1:0]             dirty;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic wr_ok;

    assign wr_ok = cfg_we && cfg_priv;

    always_comb begin
        tbl_d = tbl_q;
        if (upd_en) begin
            tbl_d.refd[upd_idx] = 1'b1;
            if (upd_dirty) begin
                tbl_d.dirty[upd_idx] = 1'b1;
            end
        end
        if (wr_ok) begin
            tbl_d.base[cfg_idx]  = cfg_base;
            tbl_d.limit[cfg_idx] = cfg_limit;
            tbl_d.perm[cfg_idx]  = cfg_perm;
            tbl_d.valid[cfg_idx] = cfg_valid;
            tbl_d.refd[cfg_idx]  = 1'b0;
            tbl_d.dirty[cfg_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign lk_base  = tbl_q.base[lk_idx];
    assign lk_limit = tbl_q.limit[lk_idx];
    assign lk_perm  = tbl_q.perm[lk_idx];
    assign lk_valid = tbl_q.valid[lk_idx];
    assign st_ref   = tbl_q.refd[st_idx];
    assign st_dirty = tbl_q.dirty[st_idx];

    // R7: an unqualified write leaves every descriptor field untouched
    p_unpriv_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> ($stable(tbl_q.base) && $stable(tbl_q.limit)
                                   && $stable(tbl_q.perm) && $stable(tbl_q.valid)));

    // R8: a clean access marks its descriptor referenced unless overwritten
    p_upd_sets_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !(wr_ok && cfg_idx == upd_idx)) |=> tbl_q.refd[$past(upd_idx)]);

    generate
        for (genvar g = 0; g < NSEG; g++) begin : g_entry_chk
            // R8: dirty is never set on an entry that is not referenced
            p_dirty_needs_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
                tbl_q.dirty[g] |-> tbl_q.refd[g]);
        end
    endgenerate

endmodule

// File: rtl/segxl_check.sv
module segxl_check
    import segxl_pkg::*;
#(
    parameter int PA_W  = 18,
    parameter int OFF_W = 14
) (
    input  logic [PA_W-1:0]   base,
    input  logic [OFF_W-1:0]  limit,
    input  logic [PERM_N-1:0] perm,
    input  logic              valid,
    input  logic [OFF_W-1:0]  offset,
    input  acc_kind_e         kind,
    output logic [PA_W-1:0]   sum,
    output fault_e            fault
);

    logic over;
    logic allowed;

    // adder and comparator both start from the raw offset
    assign sum  = base + PA_W'(offset);
    assign over = offset > limit;

    always_comb begin
        unique case (kind)
            ACC_READ:  allowed = perm[PERM_R];
            ACC_WRITE: allowed = perm[PERM_W];
            ACC_EXEC:  allowed = perm[PERM_X];
            default:   allowed = 1'b0;
        endcase
    end

    always_comb begin
        if (!valid) begin
            fault = FLT_SEG;
        end else if (over) begin
            fault = FLT_LIM;
        end else if (!allowed) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/segxl_unit.sv
module segxl_unit
    import segxl_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int SEG_W = 2,
    parameter int PA_W  = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xlate_en,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [1:0]            req_kind,
    input  logic                  cfg_we,
    input  logic                  cfg_priv,
    input  logic [SEG_W-1:0]      cfg_idx,
    input  logic [PA_W-1:0]       cfg_base,
    input  logic [VA_W-SEG_W-1:0] cfg_limit,
    input  logic [2:0]            cfg_perm,
    input  logic                  cfg_valid,
    input  logic [SEG_W-1:0]      st_idx,
    output logic                  st_ref,
    output logic                  st_dirty,
    output logic                  rsp_valid,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  rsp_seg_fault,
    output logic                  rsp_lim_fault,
    output logic                  rsp_perm_fault
);

    localparam int OFF_W = VA_W - SEG_W;
    localparam int NSEG  = 1 << SEG_W;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic            seg;
        logic            lim;
        logic            perm;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [SEG_W-1:0]  seg_idx;
    logic [OFF_W-1:0]  offset;
    logic [PA_W-1:0]   lk_base;
    logic [OFF_W-1:0]  lk_limit;
    logic [PERM_N-1:0] lk_perm;
    logic              lk_valid;
    logic [PA_W-1:0]   sum;
    fault_e            fault;
    acc_kind_e         kind;
    logic              upd_en;
    logic              upd_dirty;

    assign seg_idx = req_vaddr[VA_W-1 -: SEG_W];
    assign offset  = req_vaddr[OFF_W-1:0];
    assign kind    = acc_kind_e'(req_kind);

    segxl_table #(
        .NSEG (NSEG),
        .SEG_W(SEG_W),
        .PA_W (PA_W),
        .OFF_W(OFF_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_priv (cfg_priv),
        .cfg_idx  (cfg_idx),
        .cfg_base (cfg_base),
        .cfg_limit(cfg_limit),
        .cfg_perm (cfg_perm),
        .cfg_valid(cfg_valid),
        .lk_idx   (seg_idx),
        .lk_base  (lk_base),
        .lk_limit (lk_limit),
        .lk_perm  (lk_perm),
        .lk_valid (lk_valid),
        .upd_en   (upd_en),
        .upd_dirty(upd_dirty),
        .upd_idx  (seg_idx),
        .st_idx   (st_idx),
        .st_ref   (st_ref),
        .st_dirty (st_dirty)
    );

    segxl_check #(
        .PA_W (PA_W),
        .OFF_W(OFF_W)
    ) u_check (
        .base  (lk_base),
        .limit (lk_limit),
        .perm  (lk_perm),
        .valid (lk_valid),
        .offset(offset),
        .kind  (kind),
        .sum   (sum),
        .fault (fault)
    );

    always_comb begin
        rsp_d     = '0;
        upd_en    = 1'b0;
        upd_dirty = 1'b0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (!xlate_en) begin
                rsp_d.paddr = PA_W'(req_vaddr);
            end else begin
                unique case (fault)
                    FLT_NONE: begin
                        rsp_d.paddr = sum;
                        upd_en      = 1'b1;
                        upd_dirty   = (kind == ACC_WRITE);
                    end
                    FLT_SEG:  rsp_d.seg  = 1'b1;
                    FLT_LIM:  rsp_d.lim  = 1'b1;
                    default:  rsp_d.perm = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_paddr      = rsp_q.paddr;
    assign rsp_seg_fault  = rsp_q.seg;
    assign rsp_lim_fault  = rsp_q.lim;
    assign rsp_perm_fault = rsp_q.perm;

    // R5: never more than one fault flag per response
    p_one_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_seg_fault, rsp_lim_fault, rsp_perm_fault}));

    // R5: a faulted response carries no address
    p_fault_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_seg_fault || rsp_lim_fault || rsp_perm_fault) |-> (rsp_paddr == '0));

    // R6: pass-through returns the virtual address with no fault
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlate_en) |=> (rsp_valid && rsp_paddr == PA_W'($past(req_vaddr))
            && !rsp_seg_fault && !rsp_lim_fault && !rsp_perm_fault));

    // R10: an idle cycle yields no response and no fault
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_seg_fault && !rsp_lim_fault && !rsp_perm_fault));

    // R2: the limit flag only ever follows a translated request
    p_lim_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_lim_fault) |-> $past(req_valid && xlate_en));

endmodule

// File: tb/segxl_unit_bench.sv
module segxl_unit_bench;

    localparam int VA_W  = 16;
    localparam int SEG_W = 2;
    localparam int PA_W  = 18;
    localparam int OFF_W = VA_W - SEG_W;
    localparam int NSEG  = 1 << SEG_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xlate_en = 1'b0;
    logic              req_valid = 1'b0;
    logic [VA_W-1:0]   req_vaddr = '0;
    logic [1:0]        req_kind = '0;
    logic              cfg_we = 1'b0;
    logic              cfg_priv = 1'b0;
    logic [SEG_W-1:0]  cfg_idx = '0;
    logic [PA_W-1:0]   cfg_base = '0;
    logic [OFF_W-1:0]  cfg_limit = '0;
    logic [2:0]        cfg_perm = '0;
    logic              cfg_valid = 1'b0;
    logic [SEG_W-1:0]  st_idx = '0;
    logic              st_ref, st_dirty;
    logic              rsp_valid;
    logic [PA_W-1:0]   rsp_paddr;
    logic              rsp_seg_fault, rsp_lim_fault, rsp_perm_fault;

    int n_tests = 0;
    int n_fail  = 0;

    logic [PA_W-1:0]  m_base  [NSEG];
    logic [OFF_W-1:0] m_lim   [NSEG];
    logic [2:0]       m_perm  [NSEG];
    logic             m_val   [NSEG];
    logic             m_ref   [NSEG];
    logic             m_dirty [NSEG];

    always #4 clk = ~clk;

    segxl_unit #(.VA_W(VA_W), .SEG_W(SEG_W), .PA_W(PA_W)) u_segxl_unit (
        .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .req_valid(req_valid),
        .req_vaddr(req_vaddr), .req_kind(req_kind), .cfg_we(cfg_we),
        .cfg_priv(cfg_priv), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_perm(cfg_perm), .cfg_valid(cfg_valid),
        .st_idx(st_idx), .st_ref(st_ref), .st_dirty(st_dirty),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_seg_fault(rsp_seg_fault), .rsp_lim_fault(rsp_lim_fault),
        .rsp_perm_fault(rsp_perm_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic cfg_write(input int idx, input logic [PA_W-1:0] b, input logic [OFF_W-1:0] l,
                             input logic [2:0] p, input logic v, input logic priv);
        cfg_we = 1'b1; cfg_priv = priv; cfg_idx = SEG_W'(idx);
        cfg_base = b; cfg_limit = l; cfg_perm = p; cfg_valid = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0;
        if (priv) begin
            m_base[idx] = b; m_lim[idx] = l; m_perm[idx] = p; m_val[idx] = v;
            m_ref[idx] = 1'b0; m_dirty[idx] = 1'b0;
        end
    endtask

    task automatic access(input logic en, input logic [VA_W-1:0] va, input logic [1:0] k,
                          input string tag_over);
        int s;
        logic [OFF_W-1:0] off;
        logic ok;
        logic [PA_W-1:0] e_pa;
        logic [2:0] e_flt;
        string tg;
        s   = int'(va[VA_W-1 -: SEG_W]);
        off = va[OFF_W-1:0];
        case (k)
            2'd0: ok = m_perm[s][0];
            2'd1: ok = m_perm[s][1];
            2'd2: ok = m_perm[s][2];
            default: ok = 1'b0;
        endcase
        e_pa = '0; e_flt = 3'b000;
        if (!en) begin
            e_pa = PA_W'(va); tg = "R6";
        end else if (!m_val[s]) begin
            e_flt = 3'b100; tg = "R4";
        end else if (off > m_lim[s]) begin
            e_flt = 3'b010; tg = "R2";
        end else if (!ok) begin
            e_flt = 3'b001; tg = "R3";
        end else begin
            e_pa = m_base[s] + PA_W'(off); tg = "R1";
        end
        if (tag_over != "") tg = tag_over;
        xlate_en = en; req_valid = 1'b1; req_vaddr = va; req_kind = k;
        @(negedge clk);
        req_valid = 1'b0;
        if (en && e_flt == 3'b000) begin
            m_ref[s] = 1'b1;
            if (k == 2'd1) m_dirty[s] = 1'b1;
        end
        chk({tg, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tg, " paddr"}, 32'(rsp_paddr), 32'(e_pa));
        chk({tg, " R5 faults"}, 32'({rsp_seg_fault, rsp_lim_fault, rsp_perm_fault}), 32'(e_flt));
        st_idx = SEG_W'(s);
        #1;
        chk("R8 ref", 32'(st_ref), 32'(m_ref[s]));
        chk("R8 dirty", 32'(st_dirty), 32'(m_dirty[s]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < NSEG; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_perm[i] = '0;
            m_val[i] = 1'b0; m_ref[i] = 1'b0; m_dirty[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk("R9 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R9 faults", 32'({rsp_seg_fault, rsp_lim_fault, rsp_perm_fault}), 32'd0);
        for (int i = 0; i < NSEG; i++) begin
            st_idx = SEG_W'(i);
            #1;
            chk("R9 ref", 32'(st_ref), 32'd0);
            chk("R9 dirty", 32'(st_dirty), 32'd0);
        end
        @(negedge clk);
        // R9: every descriptor starts invalid
        access(1'b1, 16'h4010, 2'd0, "R9");

        cfg_write(0, 18'h01000, 14'h0FFF, 3'b011, 1'b1, 1'b1);
        cfg_write(1, 18'h3FF00, 14'h3FFF, 3'b101, 1'b1, 1'b1);
        cfg_write(2, 18'h00500, 14'h0010, 3'b000, 1'b0, 1'b1);
        cfg_write(3, 18'h20000, 14'h0000, 3'b111, 1'b1, 1'b1);

        // sweep: every segment, offsets around the limit, every kind
        for (int s = 0; s < NSEG; s++) begin
            for (int j = 0; j < 7; j++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [OFF_W-1:0] off;
                    case (j)
                        0: off = '0;
                        1: off = 14'd1;
                        2: off = m_lim[s] - 14'd1;
                        3: off = m_lim[s];
                        4: off = m_lim[s] + 14'd1;
                        5: off = '1;
                        default: off = 14'h0200;
                    endcase
                    access(1'b1, {SEG_W'(s), off}, 2'(k), "");
                end
            end
        end

        // R2: sum wraps past 2^PA_W but offset is in range, no fault
        access(1'b1, {2'd1, 14'h0200}, 2'd0, "R2");
        // R5: invalid, over limit and no permission together -> segment fault only
        access(1'b1, {2'd2, 14'h3000}, 2'd1, "R5");
        // R5: valid, over limit and no permission -> limit fault only
        access(1'b1, {2'd0, 14'h2000}, 2'd2, "R5");

        // R8: privileged rewrite clears reference and dirty
        access(1'b1, {2'd0, 14'h0004}, 2'd1, "R8");
        cfg_write(0, 18'h02000, 14'h0FFF, 3'b011, 1'b1, 1'b1);
        st_idx = 2'd0;
        #1;
        chk("R8 cleared ref", 32'(st_ref), 32'd0);
        chk("R8 cleared dirty", 32'(st_dirty), 32'd0);
        @(negedge clk);

        // R6: pass-through leaves status of segment 0 untouched
        access(1'b0, {2'd0, 14'h0008}, 2'd1, "R6");
        access(1'b0, 16'hFFFF, 2'd3, "R6");
        access(1'b0, {2'd2, 14'h0001}, 2'd0, "R6");

        // R7: unprivileged writes have no effect
        cfg_write(0, 18'h12345, 14'h0001, 3'b000, 1'b0, 1'b0);
        access(1'b1, {2'd0, 14'h0800}, 2'd0, "R7");
        cfg_write(2, 18'h00700, 14'h3FFF, 3'b111, 1'b1, 1'b0);
        access(1'b1, {2'd2, 14'h0001}, 2'd0, "R7");

        // R10: idle cycle
        req_valid = 1'b0;
        @(negedge clk);
        chk("R10 idle valid", 32'(rsp_valid), 32'd0);
        chk("R10 idle faults", 32'({rsp_seg_fault, rsp_lim_fault, rsp_perm_fault}), 32'd0);

        summary();
    end

endmodule